// File: doc/BRIEF.md
# Daisy-Chain Node Address Controller

This block holds the addressing state of one node in a daisy-chained serial link. It receives already decoded command frames (node ID, block ID, write flag, register address, data) with a one-cycle valid strobe. It decides whether the frame concerns this node, either through its own ID or through the broadcast ID, and raises a one-cycle addressed strobe. When the node must answer, it also raises a reply-request strobe.

An unnumbered node sits at ID 0 and keeps the link beyond it closed. The host numbers the chain one node at a time. It writes a configuration register at ID 0, and that write loads the node's new ID and its final-node flag. Once the node has a non-zero ID, it forwards frames out of the interface opposite the one the wake signal arrived on. The next node down the chain, still at ID 0, then becomes reachable.

A wake pulse returns the node to ID 0 and latches which side interface is the receive side. A static group input sets which block ID the node accepts.

Top module: `chain_node_addr_ctrl`

## Requirements
- R1: After reset and in the cycle after a wake pulse, the node ID is 0, the final flag is 0 and forwarding is off.
- R2: A wake pulse latches `wake_side_i` as the receive side (0 = low interface, 1 = high interface). The transmit/forward side is always the opposite one. Reset selects the low side for receive.
- R3: `fwd_en_o` is high exactly when the node ID is non-zero.
- R4: A frame addresses the node directly when its node ID equals the node's own ID in the range 1..30. A node still at ID 0 is addressed by frames carrying node ID 0.
- R5: Frame node ID 63 is a broadcast, and it addresses every node, whatever its own ID.
- R6: A frame block ID of 0 matches any node. Any other block ID must equal `cfg_block_id_i`, or else the frame addresses nothing.
- R7: A write at frame node ID 0 to register address 0x3F, accepted by a node at ID 0, loads data bits [5:0] as the new node ID and data bit 8 as the final flag. This happens only if the loaded ID is in 1..30; otherwise ID and flag stay unchanged.
- R8: Once a node has a non-zero ID, a write to address 0x3F leaves its ID and final flag unchanged, even when the node is addressed directly.
- R9: A directly addressed frame raises `reply_req_o`. A broadcast frame raises it only when the node's final flag is set.
- R10: `addressed_o` and `reply_req_o` are single-cycle pulses, one clock after the accepted frame's valid strobe.
- R11: A wake pulse in the same cycle as a frame strobe takes priority. No strobe follows, and the node ID is 0.
- R12: Frame node IDs 31..62 never address the node, and the node ID never holds a value above 30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_i | input | 1 | One-cycle wake pulse |
| wake_side_i | input | 1 | Side the wake arrived on (0 low, 1 high) |
| cfg_block_id_i | input | BLOCK_W | Group number this node accepts |
| frm_valid_i | input | 1 | Decoded frame strobe |
| frm_node_id_i | input | ID_W | Frame node ID |
| frm_block_id_i | input | BLOCK_W | Frame block ID |
| frm_write_i | input | 1 | Frame is a write |
| frm_addr_i | input | ADDR_W | Frame register address |
| frm_data_i | input | DATA_W | Frame data field |
| node_id_o | output | ID_W | Current node ID |
| final_o | output | 1 | Final-node flag |
| fwd_en_o | output | 1 | Forwarding to opposite side enabled |
| rx_side_o | output | 1 | Selected receive side |
| tx_side_o | output | 1 | Forwarding side |
| addressed_o | output | 1 | Node addressed strobe |
| reply_req_o | output | 1 | Node must reply strobe |

## Verification
The properties assume that `frm_valid_i` and `wake_i` are one-cycle pulses. They also assume that the frame fields are meaningful only in the strobe cycle, and that `cfg_block_id_i` is held constant. The stimulus drives every frame and wake as an isolated single-cycle pulse on the falling edge, with at least one idle cycle between frames. It keeps the block number fixed at 5. One directed case deliberately overlaps wake and a frame strobe, so that the priority rule is exercised under the same assumptions.

// File: rtl/dcn_pkg.sv
package dcn_pkg;

   typedef enum logic {
      SIDE_LOW  = 1'b0,
      SIDE_HIGH = 1'b1
   } side_e;

   typedef struct packed {
      logic hit_direct;
      logic hit_bcast;
      logic hit_unnum;
      logic cfg_reg;
   } match_t;

endpackage

// File: rtl/dcn_side_sel.sv
module dcn_side_sel
   import dcn_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  wake_i,
   input  logic  wake_side_i,
   output side_e rx_side_o,
   output side_e tx_side_o
);

   side_e rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q <= SIDE_LOW;
      end else if (wake_i) begin
         rx_q <= side_e'(wake_side_i);
      end
   end

   assign rx_side_o = rx_q;
   assign tx_side_o = (rx_q == SIDE_LOW) ? SIDE_HIGH : SIDE_LOW;

endmodule

// File: rtl/dcn_addr_match.sv
module dcn_addr_match
   import dcn_pkg::*;
#(
   parameter int ID_W         = 6,
   parameter int BLOCK_W      = 4,
   parameter int ADDR_W       = 8,
   parameter int MAX_NODE     = 30,
   parameter int ID_CFG_ADDR  = 63,
   parameter bit BLOCK_FILTER = 1'b1
) (
   input  logic [ID_W-1:0]    own_id_i,
   input  logic [BLOCK_W-1:0] own_block_i,
   input  logic [ID_W-1:0]    frm_node_id_i,
   input  logic [BLOCK_W-1:0] frm_block_id_i,
   input  logic [ADDR_W-1:0]  frm_addr_i,
   output match_t             match_o,
   output logic               block_ok_o
);

   localparam logic [ID_W-1:0]   BCAST_ID = {ID_W{1'b1}};
   localparam logic [ID_W-1:0]   MAX_ID   = ID_W'(MAX_NODE);
   localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(ID_CFG_ADDR);

   logic own_valid;

   assign own_valid = (own_id_i != '0) && (own_id_i <= MAX_ID);

   assign match_o.hit_direct = own_valid && (frm_node_id_i == own_id_i);
   assign match_o.hit_bcast  = (frm_node_id_i == BCAST_ID);
   assign match_o.hit_unnum  = (own_id_i == '0) && (frm_node_id_i == '0);
   assign match_o.cfg_reg    = (frm_addr_i == CFG_ADDR);

   generate
      if (BLOCK_FILTER) begin : g_block_filter
         assign block_ok_o = (frm_block_id_i == '0) || (frm_block_id_i == own_block_i);
      end else begin : g_block_open
         logic unused_blk;
         assign unused_blk = ^{frm_block_id_i, own_block_i};
         assign block_ok_o = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/dcn_id_reg.sv
module dcn_id_reg #(
   parameter int ID_W     = 6,
   parameter int DATA_W   = 16,
   parameter int MAX_NODE = 30,
   parameter int FN_BIT   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wake_i,
   input  logic              load_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [ID_W-1:0]   node_id_o,
   output logic              final_o
);

   localparam logic [ID_W-1:0] MAX_ID = ID_W'(MAX_NODE);

   logic [ID_W-1:0] new_id;
   logic            new_ok;
   logic [ID_W-1:0] id_q;
   logic            fn_q;

   assign new_id = data_i[ID_W-1:0];
   assign new_ok = (new_id != '0) && (new_id <= MAX_ID);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         id_q <= '0;
         fn_q <= 1'b0;
      end else if (wake_i) begin
         id_q <= '0;
         fn_q <= 1'b0;
      end else if (load_i && new_ok) begin
         id_q <= new_id;
         fn_q <= data_i[FN_BIT];
      end
   end

   assign node_id_o = id_q;
   assign final_o   = fn_q;

endmodule

// File: rtl/chain_node_addr_ctrl.sv
module chain_node_addr_ctrl
   import dcn_pkg::*;
#(
   parameter int ID_W         = 6,
   parameter int BLOCK_W      = 4,
   parameter int ADDR_W       = 8,
   parameter int DATA_W       = 16,
   parameter int MAX_NODE     = 30,
   parameter int ID_CFG_ADDR  = 63,
   parameter int FN_BIT       = 8,
   parameter bit BLOCK_FILTER = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wake_i,
   input  logic               wake_side_i,
   input  logic [BLOCK_W-1:0] cfg_block_id_i,
   input  logic               frm_valid_i,
   input  logic [ID_W-1:0]    frm_node_id_i,
   input  logic [BLOCK_W-1:0] frm_block_id_i,
   input  logic               frm_write_i,
   input  logic [ADDR_W-1:0]  frm_addr_i,
   input  logic [DATA_W-1:0]  frm_data_i,
   output logic [ID_W-1:0]    node_id_o,
   output logic               final_o,
   output logic               fwd_en_o,
   output logic               rx_side_o,
   output logic               tx_side_o,
   output logic               addressed_o,
   output logic               reply_req_o
);

   generate
      if (ID_W < 2) begin : g_bad_id_w
         $error("ID_W too small");
      end
      if (MAX_NODE < 1 || MAX_NODE >= (2 ** ID_W) - 1) begin : g_bad_max
         $error("MAX_NODE must leave room for the broadcast ID");
      end
      if (FN_BIT >= DATA_W || FN_BIT < ID_W) begin : g_bad_fn
         $error("FN_BIT must lie in the data field above the ID bits");
      end
      if (DATA_W < ID_W + 1) begin : g_bad_data
         $error("DATA_W too small");
      end
      if (ID_CFG_ADDR < 0 || ID_CFG_ADDR >= (2 ** ADDR_W)) begin : g_bad_addr
         $error("ID_CFG_ADDR outside address range");
      end
   endgenerate

   side_e           rx_side;
   side_e           tx_side;
   match_t          match;
   logic            block_ok;
   logic [ID_W-1:0] node_id;
   logic            fn;
   logic            accept;
   logic            id_load;
   logic            addr_q;
   logic            reply_q;

   dcn_side_sel u_side (
      .clk         (clk),
      .rst_n       (rst_n),
      .wake_i      (wake_i),
      .wake_side_i (wake_side_i),
      .rx_side_o   (rx_side),
      .tx_side_o   (tx_side)
   );

   dcn_addr_match #(
      .ID_W         (ID_W),
      .BLOCK_W      (BLOCK_W),
      .ADDR_W       (ADDR_W),
      .MAX_NODE     (MAX_NODE),
      .ID_CFG_ADDR  (ID_CFG_ADDR),
      .BLOCK_FILTER (BLOCK_FILTER)
   ) u_match (
      .own_id_i       (node_id),
      .own_block_i    (cfg_block_id_i),
      .frm_node_id_i  (frm_node_id_i),
      .frm_block_id_i (frm_block_id_i),
      .frm_addr_i     (frm_addr_i),
      .match_o        (match),
      .block_ok_o     (block_ok)
   );

   assign accept  = frm_valid_i && !wake_i && block_ok &&
                    (match.hit_direct || match.hit_bcast || match.hit_unnum);
   assign id_load = accept && match.hit_unnum && frm_write_i && match.cfg_reg;

   dcn_id_reg #(
      .ID_W     (ID_W),
      .DATA_W   (DATA_W),
      .MAX_NODE (MAX_NODE),
      .FN_BIT   (FN_BIT)
   ) u_id (
      .clk       (clk),
      .rst_n     (rst_n),
      .wake_i    (wake_i),
      .load_i    (id_load),
      .data_i    (frm_data_i),
      .node_id_o (node_id),
      .final_o   (fn)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= 1'b0;
         reply_q <= 1'b0;
      end else begin
         addr_q  <= accept;
         reply_q <= accept && (!match.hit_bcast || fn);
      end
   end

   assign node_id_o   = node_id;
   assign final_o     = fn;
   assign fwd_en_o    = (node_id != '0);
   assign rx_side_o   = rx_side;
   assign tx_side_o   = tx_side;
   assign addressed_o = addr_q;
   assign reply_req_o = reply_q;

endmodule

// File: rtl/dcn_checker.sv
module dcn_checker #(
   parameter int ID_W     = 6,
   parameter int BLOCK_W  = 4,
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 16,
   parameter int MAX_NODE = 30
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wake_i,
   input logic               wake_side_i,
   input logic [BLOCK_W-1:0] cfg_block_id_i,
   input logic               frm_valid_i,
   input logic [ID_W-1:0]    frm_node_id_i,
   input logic [BLOCK_W-1:0] frm_block_id_i,
   input logic               frm_write_i,
   input logic [ADDR_W-1:0]  frm_addr_i,
   input logic [DATA_W-1:0]  frm_data_i,
   input logic [ID_W-1:0]    node_id_o,
   input logic               final_o,
   input logic               fwd_en_o,
   input logic               rx_side_o,
   input logic               tx_side_o,
   input logic               addressed_o,
   input logic               reply_req_o
);

   localparam logic [ID_W-1:0] BCAST_ID = {ID_W{1'b1}};
   localparam logic [ID_W-1:0] MAX_ID   = ID_W'(MAX_NODE);

   logic unused_in;
   assign unused_in = ^{wake_side_i, cfg_block_id_i, frm_block_id_i,
                        frm_addr_i, frm_data_i, tx_side_o};

   assert_wake_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
      wake_i |=> (node_id_o == '0) && !final_o && !fwd_en_o);

   assert_side_on_wake_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_side_o) |-> $past(wake_i));

   assert_fwd_after_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fwd_en_o) |-> $past(frm_valid_i && frm_write_i));

   assert_id_change_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(node_id_o) |-> $past(wake_i) || $past(frm_valid_i && frm_write_i));

   assert_bcast_reply_final_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (reply_req_o && $past(frm_node_id_i) == BCAST_ID) |-> $past(final_o));

   assert_reply_needs_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      reply_req_o |-> addressed_o);

   assert_strobe_timing_R10: assert property (@(posedge clk) disable iff (!rst_n)
      addressed_o |-> $past(frm_valid_i));

   assert_strobe_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      addressed_o |=> !addressed_o || $past(frm_valid_i));

   assert_wake_priority_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_i && frm_valid_i) |=> !addressed_o && !reply_req_o);

   assert_id_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
      node_id_o <= MAX_ID);

endmodule

bind chain_node_addr_ctrl dcn_checker #(
   .ID_W     (ID_W),
   .BLOCK_W  (BLOCK_W),
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .MAX_NODE (MAX_NODE)
) u_dcn_checker (.*);

// File: tb/chain_node_addr_ctrl_bench.sv
`timescale 1ns/1ps
module chain_node_addr_ctrl_bench;

   typedef struct packed {
      logic        wake;
      logic        side;
      logic [5:0]  nid;
      logic [3:0]  blk;
      logic        wr;
      logic [7:0]  addr;
      logic [15:0] data;
      logic        e_addr;
      logic        e_rep;
      logic [5:0]  e_id;
      logic        e_fn;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 1'b0, 6'd0,  4'd0, 1'b0, 8'h0A, 16'h0000, 1'b1, 1'b1, 6'd0,  1'b0}, // R4 unnumbered read
      '{1'b0, 1'b0, 6'd0,  4'd0, 1'b1, 8'h3F, 16'h001F, 1'b1, 1'b1, 6'd0,  1'b0}, // R7 id 31 refused
      '{1'b0, 1'b0, 6'd0,  4'd3, 1'b1, 8'h3F, 16'h0002, 1'b0, 1'b0, 6'd0,  1'b0}, // R6 wrong block
      '{1'b0, 1'b0, 6'd0,  4'd5, 1'b1, 8'h3F, 16'h0002, 1'b1, 1'b1, 6'd2,  1'b0}, // R7 enumerate to 2
      '{1'b0, 1'b0, 6'd0,  4'd0, 1'b1, 8'h3F, 16'h0007, 1'b0, 1'b0, 6'd2,  1'b0}, // R4 id 0 no longer ours
      '{1'b0, 1'b0, 6'd2,  4'd0, 1'b1, 8'h3F, 16'h0109, 1'b1, 1'b1, 6'd2,  1'b0}, // R8 re-config ignored
      '{1'b0, 1'b0, 6'd2,  4'd0, 1'b0, 8'h10, 16'h0000, 1'b1, 1'b1, 6'd2,  1'b0}, // R4 direct read
      '{1'b0, 1'b0, 6'd3,  4'd0, 1'b0, 8'h10, 16'h0000, 1'b0, 1'b0, 6'd2,  1'b0}, // R4 other node
      '{1'b0, 1'b0, 6'd63, 4'd0, 1'b1, 8'h20, 16'h1234, 1'b1, 1'b0, 6'd2,  1'b0}, // R9 bcast, not final
      '{1'b0, 1'b0, 6'd63, 4'd6, 1'b1, 8'h20, 16'h1234, 1'b0, 1'b0, 6'd2,  1'b0}, // R6 bcast other group
      '{1'b1, 1'b1, 6'd0,  4'd0, 1'b1, 8'h3F, 16'h011E, 1'b1, 1'b1, 6'd30, 1'b1}, // R1 R7 wake, id 30 final
      '{1'b0, 1'b0, 6'd63, 4'd5, 1'b1, 8'h20, 16'h0000, 1'b1, 1'b1, 6'd30, 1'b1}, // R9 bcast write final
      '{1'b0, 1'b0, 6'd63, 4'd0, 1'b0, 8'h20, 16'h0000, 1'b1, 1'b1, 6'd30, 1'b1}, // R5 bcast read
      '{1'b0, 1'b0, 6'd31, 4'd0, 1'b1, 8'h20, 16'h0000, 1'b0, 1'b0, 6'd30, 1'b1}, // R12 id 31 unmatched
      '{1'b0, 1'b0, 6'd30, 4'd5, 1'b0, 8'h11, 16'h0000, 1'b1, 1'b1, 6'd30, 1'b1}  // R4 direct at 30
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wake_i = 1'b0;
   logic        wake_side_i = 1'b0;
   logic [3:0]  cfg_block_id_i = 4'd5;
   logic        frm_valid_i = 1'b0;
   logic [5:0]  frm_node_id_i = '0;
   logic [3:0]  frm_block_id_i = '0;
   logic        frm_write_i = 1'b0;
   logic [7:0]  frm_addr_i = '0;
   logic [15:0] frm_data_i = '0;
   logic [5:0]  node_id_o;
   logic        final_o, fwd_en_o, rx_side_o, tx_side_o, addressed_o, reply_req_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   chain_node_addr_ctrl u_chain_node_addr_ctrl (.*);

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic drive_frame(input vec_t v, input logic with_wake);
      frm_node_id_i  = v.nid;
      frm_block_id_i = v.blk;
      frm_write_i    = v.wr;
      frm_addr_i     = v.addr;
      frm_data_i     = v.data;
      frm_valid_i    = 1'b1;
      wake_i         = with_wake;
      @(negedge clk);
      frm_valid_i    = 1'b0;
      wake_i         = 1'b0;
   endtask

   task automatic pulse_wake(input logic side);
      wake_i      = 1'b1;
      wake_side_i = side;
      @(negedge clk);
      wake_i      = 1'b0;
      @(negedge clk);
   endtask

   task automatic run_vec(input vec_t v, input int idx);
      if (v.wake) begin
         pulse_wake(v.side);
         check("R1 id after wake", node_id_o, 0);
         check("R2 rx side after wake", rx_side_o, v.side);
      end
      drive_frame(v, 1'b0);
      check($sformatf("R4 R5 R6 addressed vec %0d", idx), addressed_o, v.e_addr);
      check($sformatf("R9 reply vec %0d", idx), reply_req_o, v.e_rep);
      check($sformatf("R7 R8 id vec %0d", idx), node_id_o, v.e_id);
      check($sformatf("R7 fn vec %0d", idx), final_o, v.e_fn);
      check($sformatf("R3 fwd vec %0d", idx), fwd_en_o, (v.e_id != 0));
      @(negedge clk);
      check($sformatf("R10 addressed drop vec %0d", idx), addressed_o, 0);
      check($sformatf("R10 reply drop vec %0d", idx), reply_req_o, 0);
   endtask

   initial begin
      vec_t d;
      repeat (3) @(negedge clk);
      // R1 R2 reset state
      check("R1 reset id", node_id_o, 0);
      check("R1 reset fn", final_o, 0);
      check("R3 reset fwd", fwd_en_o, 0);
      check("R10 reset addressed", addressed_o, 0);
      check("R2 reset rx side", rx_side_o, 0);
      check("R2 reset tx side", tx_side_o, 1);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         run_vec(VEC[i], i);
      end
      check("R2 tx opposite after high wake", tx_side_o, 0);

      // R11 wake together with a broadcast write
      d = '{1'b0, 1'b0, 6'd63, 4'd0, 1'b1, 8'h20, 16'h0000, 1'b0, 1'b0, 6'd0, 1'b0};
      wake_side_i = 1'b0;
      drive_frame(d, 1'b1);
      check("R11 no strobe with wake", addressed_o, 0);
      check("R11 no reply with wake", reply_req_o, 0);
      check("R11 id zero", node_id_o, 0);
      check("R2 rx low after wake", rx_side_o, 0);

      // R7 data id 0 refused
      d = '{1'b0, 1'b0, 6'd0, 4'd0, 1'b1, 8'h3F, 16'h0100, 1'b1, 1'b1, 6'd0, 1'b0};
      run_vec(d, 100);

      // R12 data id 62 refused
      d = '{1'b0, 1'b0, 6'd0, 4'd0, 1'b1, 8'h3F, 16'h013E, 1'b1, 1'b1, 6'd0, 1'b0};
      run_vec(d, 101);

      // R7 write to other address at id 0 does not number the node
      d = '{1'b0, 1'b0, 6'd0, 4'd0, 1'b1, 8'h3E, 16'h0004, 1'b1, 1'b1, 6'd0, 1'b0};
      run_vec(d, 102);

      // R1 enumerate then reset
      d = '{1'b0, 1'b0, 6'd0, 4'd5, 1'b1, 8'h3F, 16'h0104, 1'b1, 1'b1, 6'd4, 1'b1};
      run_vec(d, 103);
      pulse_wake(1'b1);
      d = '{1'b0, 1'b0, 6'd0, 4'd5, 1'b1, 8'h3F, 16'h0005, 1'b1, 1'b1, 6'd5, 1'b0};
      run_vec(d, 104);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 id after reset", node_id_o, 0);
      check("R3 fwd after reset", fwd_en_o, 0);
      check("R2 rx side after reset", rx_side_o, 0);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule